// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the codec-side serializer for the status-and-capture direction of a serial audio link. Each frame is 256 bits long. It opens with a 16-bit tag slot, and twelve 20-bit data slots follow. The controller starts a frame by raising a frame-sync line. The block samples that line on the falling edge of the bit clock. It then shifts the frame out on a serial data pin, changing the pin on rising edges so that the controller can sample it on the falling edges that follow.

The parallel side has four inputs:
- a ready flag;
- a four-bit valid mask, one flag for each of the four content slots;
- a flat bus carrying the four 20-bit slot payloads;
- (implicitly) the timing of the frame start.

These values are captured once, at the moment a frame is accepted, so the source may change them while the frame is in flight. The block also guards the frame length. A sync edge that arrives before the current frame has run its full 256 bits is refused, and the data pin is forced low. It stays low until a sync edge arrives at or after a legal frame boundary.

Top module: `slink_tx`

## Requirements
- R1: While reset is high, and afterwards until a frame is accepted, `sdata_out` is 0.
- R2: A low-to-high change of `sync_in` takes effect only through its falling-edge sample. The first bit of an accepted frame, the ready flag (tag bit 15), appears on `sdata_out` at the first rising edge after the falling edge that saw `sync_in` high.
- R3: Tag bits 14, 13, 12 and 11 carry `slot_valid[0]`, `[1]`, `[2]` and `[3]` (slots 1 to 4 in that order). Tag bits 10 to 0 are 0.
- R4: Slots 1 to 4 follow the tag, each sent MSB first. Slot n takes `slot_data[(n-1)*20 +: 20]` when `slot_valid[n-1]` is 1, and all zeros otherwise.
- R5: Data slots 5 to 12 (the last 160 bits of the frame) are always 0.
- R7: The ready flag, valid mask and payloads are captured at frame acceptance. Changes to them during the frame do not alter the bits sent.
- R8: A sync rising edge seen before 256 bits of the current frame have gone out is ignored. From the next rising edge, `sdata_out` is 0 for the rest of that frame's 256-bit span. Between frames the pin is 0.
- R9: A sync edge is accepted once the frame in progress has sent all 256 bits, either directly after the last bit (back-to-back frames) or any number of bits later.
- R10: The first sync rising edge after reset is accepted as a frame start, whatever happened before the reset.
- R11: A sync line held high past the end of a frame does not start another frame. Only a new low-to-high change does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data changes on rising edges, sync is sampled on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync from the controller |
| codec_ready | input | 1 | Ready flag placed in tag bit 15 |
| slot_valid | input | 4 | Valid flags for slots 1 to 4 (bit 0 is slot 1) |
| slot_data | input | 80 | Payloads for slots 1 to 4, slot 1 in bits 19:0 |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
The frame content is swept over every combination of ready flag and valid mask, with a distinct payload pattern per combination. This separates tag-bit ordering errors from slot-position and slot-zeroing errors. The parallel inputs are toggled in the middle of every frame, so any design that reads them late shows up as a mismatch against the values captured at the start. Sync timing is exercised in five ways:
- back-to-back edges exactly at the frame boundary;
- late edges after an idle gap;
- early edges at two different offsets;
- a line held high across the boundary;
- a reset in the middle of a frame.

Together these distinguish an accept window that is too wide, too narrow or misplaced.

// File: rtl/slink_pkg.sv
package slink_pkg;
  // Default link geometry.
  localparam int SLK_TAG_W      = 16;
  localparam int SLK_SLOT_W     = 20;
  localparam int SLK_NUM_SLOTS  = 12;
  localparam int SLK_USED_SLOTS = 4;

  // Outcome of a falling-edge sync event as seen by the frame timer.
  typedef enum logic [1:0] {
    SYNC_NONE   = 2'd0,
    SYNC_ACCEPT = 2'd1,
    SYNC_REJECT = 2'd2
  } slk_sync_e;
endpackage

// File: rtl/slink_sync_edge.sv
module slink_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic sync_rise
);
  logic smp_now;
  logic smp_prev;

  // Falling-edge sampling; the reset value of 1 demands a genuine low-to-high change.
  always_ff @(negedge clk) begin
    if (rst) begin
      smp_now  <= 1'b1;
      smp_prev <= 1'b1;
    end else begin
      smp_prev <= smp_now;
      smp_now  <= sync_in;
    end
  end

  // Held stable from one falling edge to the next, so exactly one rising edge sees it.
  assign sync_rise = smp_now & ~smp_prev;
endmodule

// File: rtl/slink_frame_timer.sv
module slink_frame_timer
  import slink_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_rise,
  output logic             load,
  output logic             squelch,
  output logic [CNT_W-1:0] bitpos
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic      span_done;
  slk_sync_e verdict;

  assign span_done = (bitpos == FULL);

  always_comb begin
    verdict = SYNC_NONE;
    if (sync_rise) verdict = span_done ? SYNC_ACCEPT : SYNC_REJECT;
  end

  assign load    = (verdict == SYNC_ACCEPT);
  assign squelch = (verdict == SYNC_REJECT);

  // bitpos counts bits already driven; it saturates at FULL, which doubles as "idle".
  always_ff @(posedge clk) begin
    if (rst)             bitpos <= FULL;
    else if (load)       bitpos <= CNT_W'(1);
    else if (!span_done) bitpos <= bitpos + CNT_W'(1);
  end
endmodule

// File: rtl/slink_frame_build.sv
module slink_frame_build #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int NUM_SLOTS  = 12,
  parameter int USED_SLOTS = 4,
  parameter int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W
) (
  input  logic                         ready,
  input  logic [USED_SLOTS-1:0]        valid,
  input  logic [USED_SLOTS*SLOT_W-1:0] payload,
  output logic [FRAME_BITS-1:0]        frame
);
  localparam int BODY_TOP = FRAME_BITS - TAG_W - 1;

  logic [TAG_W-1:0] tag;

  always_comb begin
    tag = '0;
    tag[TAG_W-1] = ready;
    for (int i = 0; i < USED_SLOTS; i++) tag[TAG_W-2-i] = valid[i];
  end

  assign frame[FRAME_BITS-1 -: TAG_W] = tag;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < USED_SLOTS) begin : g_used
      assign frame[BODY_TOP - s*SLOT_W -: SLOT_W] =
        valid[s] ? payload[s*SLOT_W +: SLOT_W] : '0;
    end else begin : g_zero
      assign frame[BODY_TOP - s*SLOT_W -: SLOT_W] = '0;
    end
  end
endmodule

// File: rtl/slink_frame_shift.sv
module slink_frame_shift #(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  squelch,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic                  sdata
);
  logic [FRAME_BITS-1:0] shreg;

  // Zero fill means the pin falls silent by itself after the last bit.
  always_ff @(posedge clk) begin
    if (rst || squelch) begin
      shreg <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sdata <= frame_in[FRAME_BITS-1];
      shreg <= {frame_in[FRAME_BITS-2:0], 1'b0};
    end else begin
      sdata <= shreg[FRAME_BITS-1];
      shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/slink_tx.sv
module slink_tx #(
  parameter int TAG_W      = slink_pkg::SLK_TAG_W,
  parameter int SLOT_W     = slink_pkg::SLK_SLOT_W,
  parameter int NUM_SLOTS  = slink_pkg::SLK_NUM_SLOTS,
  parameter int USED_SLOTS = slink_pkg::SLK_USED_SLOTS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_in,
  input  logic                         codec_ready,
  input  logic [USED_SLOTS-1:0]        slot_valid,
  input  logic [USED_SLOTS*SLOT_W-1:0] slot_data,
  output logic                         sdata_out
);
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic                  rise_w;
  logic                  load_w;
  logic                  squelch_w;
  logic [CNT_W-1:0]      bitpos_w;
  logic [FRAME_BITS-1:0] frame_w;

  slink_sync_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (sync_in),
    .sync_rise (rise_w)
  );

  slink_frame_timer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .sync_rise (rise_w),
    .load      (load_w),
    .squelch   (squelch_w),
    .bitpos    (bitpos_w)
  );

  slink_frame_build #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .USED_SLOTS(USED_SLOTS), .FRAME_BITS(FRAME_BITS)
  ) u_build (
    .ready   (codec_ready),
    .valid   (slot_valid),
    .payload (slot_data),
    .frame   (frame_w)
  );

  slink_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load_w),
    .squelch  (squelch_w),
    .frame_in (frame_w),
    .sdata    (sdata_out)
  );
endmodule

// File: rtl/slink_tx_chk.sv
module slink_tx_chk #(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             squelch,
  input logic [CNT_W-1:0] bitpos,
  input logic             sdata,
  input logic             ready
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  assert_first_bit_ready_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (sdata == $past(ready)));

  assert_early_silent_R8: assert property (@(posedge clk) disable iff (rst)
    squelch |=> !sdata);

  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (bitpos == FULL && !load) |=> !sdata);

  assert_restart_count_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (bitpos == CNT_W'(1)));

  assert_step_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && bitpos != FULL) |=> (bitpos == $past(bitpos) + CNT_W'(1)));

  assert_hold_full_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && bitpos == FULL) |=> (bitpos == FULL));
endmodule

bind slink_tx slink_tx_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load_w),
  .squelch (squelch_w),
  .bitpos  (bitpos_w),
  .sdata   (sdata_out),
  .ready   (codec_ready)
);

// File: tb/sim_slink_tx.sv
module sim_slink_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_in = 1'b0;
  logic        codec_ready = 1'b0;
  logic [3:0]  slot_valid = '0;
  logic [79:0] slot_data = '0;
  logic        sdata_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  slink_tx u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .codec_ready(codec_ready),
    .slot_valid(slot_valid), .slot_data(slot_data), .sdata_out(sdata_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_err++;
      n_chk++;
      $display("FAIL R9 watchdog actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Bit k of the frame (k = 0 is sent first), worked out per bit position.
  function automatic logic [255:0] exp_frame(input logic rdy, input logic [3:0] v,
                                             input logic [79:0] d);
    logic [255:0] f;
    f = '0;
    for (int k = 0; k < 256; k++) begin
      logic b;
      b = 1'b0;
      if (k == 0) b = rdy;
      else if (k <= 4) b = v[k-1];
      else if (k >= 16) begin
        int s;
        int o;
        s = (k - 16) / 20;
        o = (k - 16) % 20;
        if (s < 4 && v[s]) b = d[s*20 + 19 - o];
      end
      f[255-k] = b;
    end
    return f;
  endfunction

  task automatic set_inputs(input int p);
    codec_ready = p[0];
    slot_valid  = p[4:1];
    for (int i = 0; i < 4; i++)
      slot_data[i*20 +: 20] = 20'((p * 7919 + i * 1237 + 3) ^ 20'hA5C3E);
  endtask

  task automatic perturb();
    codec_ready = ~codec_ready;
    slot_valid  = ~slot_valid;
    slot_data   = ~slot_data ^ 80'h5A5A_1234_9876_FEDC_0F0F;
  endtask

  // Raises sync now (just after a rising edge) and reads 256 bits.
  // early_at >= 0: a second sync edge makes bit early_at onward silent.
  task automatic run_frame(input int early_at, input bit hold,
                           output logic [255:0] got, output logic [255:0] expv);
    sync_in = 1'b1;
    expv = exp_frame(codec_ready, slot_valid, slot_data);
    for (int k = 0; k < 256; k++) begin
      step();
      got[255-k] = sdata_out;
      if (k == 15 && !hold) sync_in = 1'b0;
      if (k == 50) perturb();
      if (early_at >= 0 && k == early_at - 1) sync_in = 1'b1;
      if (early_at >= 0 && k == early_at + 5) sync_in = 1'b0;
    end
    if (early_at >= 0)
      for (int k = early_at; k < 256; k++) expv[255-k] = 1'b0;
  endtask

  initial begin
    logic [255:0] got;
    logic [255:0] expv;
    logic [255:0] idle;

    // R1: reset and idle before any sync.
    idle = '0;
    for (int i = 0; i < 4; i++) begin
      step();
      idle[i] = sdata_out;
    end
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      idle[10 + i] = sdata_out;
    end
    chk("R1 idle after reset", idle, '0);

    // R10: first sync after reset is taken.
    set_inputs(31);
    run_frame(-1, 1'b0, got, expv);
    chk("R10 first frame", got, expv);

    // Sweep all ready/valid combinations, back to back (R9), inputs toggled mid-frame (R7).
    for (int p = 0; p < 32; p++) begin
      set_inputs(p);
      run_frame(-1, 1'b0, got, expv);
      chk("R2 ready bit", {255'd0, got[255]}, {255'd0, expv[255]});
      chk("R3 tag flags", {240'd0, got[254:240]}, {240'd0, expv[254:240]});
      chk("R4 used slots", {176'd0, got[239:160]}, {176'd0, expv[239:160]});
      chk("R5 unused slots", {96'd0, got[159:0]}, '0);
      chk("R9 back-to-back frame", got, expv);
    end

    // R7: a frame whose inputs all flip mid-frame.
    set_inputs(21);
    run_frame(-1, 1'b0, got, expv);
    chk("R7 inputs captured at start", got, expv);

    // R8: early sync at two offsets, then a legal frame right after each.
    set_inputs(13);
    run_frame(100, 1'b0, got, expv);
    chk("R8 early sync at bit 100", got, expv);
    set_inputs(26);
    run_frame(-1, 1'b0, got, expv);
    chk("R9 frame after early sync", got, expv);
    set_inputs(7);
    run_frame(20, 1'b0, got, expv);
    chk("R8 early sync at bit 20", got, expv);
    set_inputs(30);
    run_frame(-1, 1'b0, got, expv);
    chk("R9 frame after second early sync", got, expv);

    // R8 idle gap then R9 late sync.
    idle = '0;
    for (int i = 0; i < 40; i++) begin
      step();
      idle[i] = sdata_out;
    end
    chk("R8 silent between frames", idle, '0);
    set_inputs(19);
    run_frame(-1, 1'b0, got, expv);
    chk("R9 late sync", got, expv);

    // R11: sync held high through the boundary.
    set_inputs(27);
    run_frame(-1, 1'b1, got, expv);
    chk("R11 held-sync frame", got, expv);
    idle = '0;
    for (int i = 0; i < 44; i++) begin
      step();
      idle[i] = sdata_out;
    end
    sync_in = 1'b0;
    chk("R11 no restart while high", idle, '0);
    step();

    // R10: reset mid-frame, then a sync well before 256 bits is taken.
    set_inputs(9);
    sync_in = 1'b1;
    for (int i = 0; i < 50; i++) begin
      step();
      if (i == 15) sync_in = 1'b0;
    end
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    step();
    set_inputs(22);
    run_frame(-1, 1'b0, got, expv);
    chk("R10 frame after mid-frame reset", got, expv);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule